// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block is the parent side of an MSI protocol shared by a small set of private L1 data caches. A child cache asks for a line in S or M. The controller compares that request with its shadow view of every other child. It sends downgrade requests to each child whose copy conflicts with the request and waits for every one of them to answer. It writes any dirty data returned from M back to memory. If the requester held nothing, it fetches the line from a long-latency memory port. It then sends the upgrade response (the grant). All traffic uses line addresses, which are byte addresses with the 6 offset bits dropped for 64-byte lines.

There is no full directory. For each child and each L1 row, the controller keeps a copy of the tag and the MSI state that it last gave that child. A child whose stored tag differs from the requested tag counts as Invalid for that line. The controller handles one request at a time through a state machine with these states:

- ST_IDLE accepts a request and moves to ST_LOOKUP.
- ST_LOOKUP moves to ST_DNGRD when a conflict exists. Otherwise it moves to ST_MEMRD when the requester is in I, or to ST_GRANT when it is not.
- ST_DNGRD leaves once nothing remains to send or to wait for. It moves to ST_WRBACK when dirty data arrived, and otherwise to ST_MEMRD or ST_GRANT by the same rule as ST_LOOKUP.
- ST_WRBACK moves to ST_MEMRD or ST_GRANT once memory accepts the write.
- ST_MEMRD moves to ST_MEMWT once memory accepts the read.
- ST_MEMWT moves to ST_GRANT when the read data arrives.
- ST_GRANT returns to ST_IDLE once the child accepts the response.

Top module: `msi_dir_ctrl`

## Requirements
- R1: After reset every shadow state is I, the controller accepts a request at once, and no downgrade, memory or grant output is valid.
- R2: A line address splits into the row index (low 4 bits) and the tag (upper 22 bits). A child whose stored tag at that row differs from the requested tag is treated as I and receives no downgrade.
- R3: State codes are I=0, S=1 and M=2. A request for S sends a downgrade to S to each other child in M. A request for M sends a downgrade to I to each other child in S or M. Each downgrade carries the requested line, and no other child receives one.
- R4: The grant is sent only after a downgrade response has arrived from every child that was sent a downgrade request.
- R5: When a downgraded child was in M, the data in its response is written to memory before the line is read.
- R6: A requester in I causes exactly one memory read. Its grant carries data-valid=1 and the current line contents, including dirty data written back during the same request.
- R7: A requester already in S that asks for M causes no memory read, and its grant carries data-valid=0.
- R8: The grant carries the requested state, and later requests see the requester in that state with that tag.
- R9: Without conflicts, a grant to a requester in S is valid 2 cycles after the request is accepted. A read for a requester in I is issued 2 cycles after the request is accepted. In every case the grant is valid 1 cycle after the read data is accepted.
- R10: New requests are refused from the cycle after a request is accepted until the grant has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| creq_valid | input | 1 | Upgrade request from a child is valid |
| creq_ready | output | 1 | Controller can accept an upgrade request |
| creq_child | input | CID_W | Requesting child |
| creq_line | input | LINE_W | Requested line address |
| creq_state | input | 2 | Requested state (S=1, M=2) |
| cresp_valid | input | 1 | Downgrade response is valid |
| cresp_ready | output | 1 | Controller can accept a downgrade response |
| cresp_child | input | CID_W | Responding child |
| cresp_line | input | LINE_W | Line being downgraded |
| cresp_state | input | 2 | State the child moved to |
| cresp_data | input | DATA_W | Line data, meaningful when the child was in M |
| dgreq_valid | output | 1 | Downgrade request is valid |
| dgreq_ready | input | 1 | Child accepts the downgrade request |
| dgreq_child | output | CID_W | Child being downgraded |
| dgreq_line | output | LINE_W | Line to downgrade |
| dgreq_state | output | 2 | State the child must move to |
| grant_valid | output | 1 | Upgrade response is valid |
| grant_ready | input | 1 | Child accepts the upgrade response |
| grant_child | output | CID_W | Child receiving the grant |
| grant_line | output | LINE_W | Granted line |
| grant_state | output | 2 | Granted state |
| grant_data_valid | output | 1 | grant_data holds the line contents |
| grant_data | output | DATA_W | Line contents |
| mem_req_valid | output | 1 | Memory request is valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write back, 0 = read |
| mem_req_line | output | LINE_W | Line address for memory |
| mem_req_data | output | DATA_W | Write data |
| mem_resp_valid | input | 1 | Read data from memory is valid |
| mem_resp_ready | output | 1 | Controller accepts the read data |
| mem_resp_data | input | DATA_W | Read data |

## Verification
Every stimulus is applied at a falling edge. The bench numbers the falling edges that follow an accepted request, so each output is checked at the falling edge where it becomes valid. A grant to a requester in S with no conflicts is due at edge 2. A memory read with no conflicts is due at edge 2. A grant that follows a read is due one edge after the read data is driven, that is MEM_LAT+1 edges after the read appeared. Downgrades, writebacks and reads are checked at the edge where each appears, against sets and order that the bench's own model of the child caches predicts. Their exact cycles are not fixed while responses are still pending.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;

    typedef enum logic [1:0] {
        MSI_I = 2'd0,
        MSI_S = 2'd1,
        MSI_M = 2'd2
    } msi_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DNGRD,
        ST_WRBACK,
        ST_MEMRD,
        ST_MEMWT,
        ST_GRANT
    } dir_st_e;

endpackage

// File: rtl/msi_shadow_dir.sv
module msi_shadow_dir
    import msi_dir_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int ROWS  = 16,
    parameter int TAG_W = 22,
    parameter int CID_W = 1,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag   [NCORE],
    output msi_e             rd_state [NCORE],
    input  logic             wr_en,
    input  logic [CID_W-1:0] wr_child,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_tag_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  msi_e             wr_state
);

    for (genvar c = 0; c < NCORE; c++) begin : g_child
        logic [TAG_W-1:0] tag_q [ROWS];
        msi_e             st_q  [ROWS];
        logic             sel;

        assign sel = wr_en && (wr_child == CID_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    st_q[r]  <= MSI_I;
                    tag_q[r] <= '0;
                end
            end else if (sel) begin
                st_q[wr_idx] <= wr_state;
                if (wr_tag_en) begin
                    tag_q[wr_idx] <= wr_tag;
                end
            end
        end

        assign rd_tag[c]   = tag_q[rd_idx];
        assign rd_state[c] = st_q[rd_idx];
    end

endmodule

// File: rtl/msi_conflict.sv
module msi_conflict
    import msi_dir_pkg::*;
#(
    parameter int NCORE = 2,
    parameter int TAG_W = 22,
    parameter int CID_W = 1
) (
    input  logic [TAG_W-1:0] rd_tag   [NCORE],
    input  msi_e             rd_state [NCORE],
    input  logic [TAG_W-1:0] look_tag,
    input  logic [CID_W-1:0] req_child,
    input  msi_e             want,
    output logic [NCORE-1:0] dg_mask,
    output msi_e             req_cur
);

    msi_e eff [NCORE];

    always_comb begin
        req_cur = MSI_I;
        dg_mask = '0;
        for (int c = 0; c < NCORE; c++) begin
            eff[c] = (rd_tag[c] == look_tag) ? rd_state[c] : MSI_I;
            if (CID_W'(c) == req_child) begin
                req_cur = eff[c];
            end else if (want == MSI_M) begin
                dg_mask[c] = (eff[c] != MSI_I);
            end else begin
                dg_mask[c] = (eff[c] == MSI_M);
            end
        end
    end

endmodule

// File: rtl/msi_dg_tracker.sv
module msi_dg_tracker #(
    parameter int NCORE = 2,
    parameter int CID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NCORE-1:0] load_mask,
    input  logic             send_fire,
    input  logic             resp_fire,
    input  logic [CID_W-1:0] resp_child,
    output logic [NCORE-1:0] send_mask,
    output logic [NCORE-1:0] wait_mask,
    output logic [CID_W-1:0] pick
);

    logic [NCORE-1:0] send_q;
    logic [NCORE-1:0] wait_q;

    always_comb begin
        pick = '0;
        for (int c = NCORE - 1; c >= 0; c--) begin
            if (send_q[c]) begin
                pick = CID_W'(c);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            send_q <= '0;
            wait_q <= '0;
        end else if (load) begin
            send_q <= load_mask;
            wait_q <= '0;
        end else begin
            if (send_fire) begin
                send_q[pick] <= 1'b0;
                wait_q[pick] <= 1'b1;
            end
            if (resp_fire) begin
                wait_q[resp_child] <= 1'b0;
            end
        end
    end

    assign send_mask = send_q;
    assign wait_mask = wait_q;

    // R4
    resp_from_waited_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fire |-> wait_q[resp_child]);

    // R4
    no_stale_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (wait_q == '0));

endmodule

// File: rtl/msi_dir_ctrl.sv
module msi_dir_ctrl
    import msi_dir_pkg::*;
#(
    parameter int NCORE  = 2,
    parameter int ROWS   = 16,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int DATA_W = 64,
    localparam int CID_W  = (NCORE > 1) ? $clog2(NCORE) : 1,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int IDX_W  = $clog2(ROWS),
    localparam int TAG_W  = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              creq_valid,
    output logic              creq_ready,
    input  logic [CID_W-1:0]  creq_child,
    input  logic [LINE_W-1:0] creq_line,
    input  logic [1:0]        creq_state,
    input  logic              cresp_valid,
    output logic              cresp_ready,
    input  logic [CID_W-1:0]  cresp_child,
    input  logic [LINE_W-1:0] cresp_line,
    input  logic [1:0]        cresp_state,
    input  logic [DATA_W-1:0] cresp_data,
    output logic              dgreq_valid,
    input  logic              dgreq_ready,
    output logic [CID_W-1:0]  dgreq_child,
    output logic [LINE_W-1:0] dgreq_line,
    output logic [1:0]        dgreq_state,
    output logic              grant_valid,
    input  logic              grant_ready,
    output logic [CID_W-1:0]  grant_child,
    output logic [LINE_W-1:0] grant_line,
    output logic [1:0]        grant_state,
    output logic              grant_data_valid,
    output logic [DATA_W-1:0] grant_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [DATA_W-1:0] mem_req_data,
    input  logic              mem_resp_valid,
    output logic              mem_resp_ready,
    input  logic [DATA_W-1:0] mem_resp_data
);

    dir_st_e state_q, state_d;

    logic [CID_W-1:0]  req_child_q;
    logic [LINE_W-1:0] req_line_q;
    msi_e              want_q;
    msi_e              cur_q;
    logic              wb_pend_q;
    logic [DATA_W-1:0] wb_data_q;
    logic [DATA_W-1:0] line_data_q;

    logic [TAG_W-1:0]  rd_tag   [NCORE];
    msi_e              rd_state [NCORE];
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [NCORE-1:0]  dg_mask;
    msi_e              look_cur;
    logic [NCORE-1:0]  send_mask;
    logic [NCORE-1:0]  wait_mask;
    logic [CID_W-1:0]  pick;

    logic cresp_fire, dgreq_fire, grant_fire, resp_dirty;
    logic sh_wr_en, sh_tag_en;
    logic [CID_W-1:0] sh_child;
    msi_e sh_state;

    assign look_idx = req_line_q[IDX_W-1:0];
    assign look_tag = req_line_q[LINE_W-1:IDX_W];

    assign cresp_fire = cresp_valid && cresp_ready;
    assign dgreq_fire = dgreq_valid && dgreq_ready;
    assign grant_fire = grant_valid && grant_ready;
    assign resp_dirty = (rd_state[cresp_child] == MSI_M);

    assign sh_tag_en = (state_q == ST_GRANT);
    assign sh_wr_en  = grant_fire || cresp_fire;
    assign sh_child  = sh_tag_en ? req_child_q : cresp_child;
    assign sh_state  = sh_tag_en ? want_q : msi_e'(cresp_state);

    msi_shadow_dir #(
        .NCORE(NCORE), .ROWS(ROWS), .TAG_W(TAG_W), .CID_W(CID_W), .IDX_W(IDX_W)
    ) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_tag   (rd_tag),
        .rd_state (rd_state),
        .wr_en    (sh_wr_en),
        .wr_child (sh_child),
        .wr_idx   (look_idx),
        .wr_tag_en(sh_tag_en),
        .wr_tag   (look_tag),
        .wr_state (sh_state)
    );

    msi_conflict #(
        .NCORE(NCORE), .TAG_W(TAG_W), .CID_W(CID_W)
    ) conflict_i (
        .rd_tag   (rd_tag),
        .rd_state (rd_state),
        .look_tag (look_tag),
        .req_child(req_child_q),
        .want     (want_q),
        .dg_mask  (dg_mask),
        .req_cur  (look_cur)
    );

    msi_dg_tracker #(
        .NCORE(NCORE), .CID_W(CID_W)
    ) tracker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_LOOKUP),
        .load_mask (dg_mask),
        .send_fire (dgreq_fire),
        .resp_fire (cresp_fire),
        .resp_child(cresp_child),
        .send_mask (send_mask),
        .wait_mask (wait_mask),
        .pick      (pick)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (creq_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (dg_mask != '0)          state_d = ST_DNGRD;
                else if (look_cur == MSI_I) state_d = ST_MEMRD;
                else                        state_d = ST_GRANT;
            end
            ST_DNGRD: begin
                if (send_mask == '0 && wait_mask == '0) begin
                    if (wb_pend_q)           state_d = ST_WRBACK;
                    else if (cur_q == MSI_I) state_d = ST_MEMRD;
                    else                     state_d = ST_GRANT;
                end
            end
            ST_WRBACK: begin
                if (mem_req_ready) state_d = (cur_q == MSI_I) ? ST_MEMRD : ST_GRANT;
            end
            ST_MEMRD: begin
                if (mem_req_ready) state_d = ST_MEMWT;
            end
            ST_MEMWT: begin
                if (mem_resp_valid) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (grant_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_child_q <= '0;
            req_line_q  <= '0;
            want_q      <= MSI_I;
            cur_q       <= MSI_I;
            wb_pend_q   <= 1'b0;
            wb_data_q   <= '0;
            line_data_q <= '0;
        end else begin
            if (state_q == ST_IDLE && creq_valid) begin
                req_child_q <= creq_child;
                req_line_q  <= creq_line;
                want_q      <= msi_e'(creq_state);
                wb_pend_q   <= 1'b0;
            end
            if (state_q == ST_LOOKUP) begin
                cur_q <= look_cur;
            end
            if (cresp_fire && resp_dirty) begin
                wb_pend_q <= 1'b1;
                wb_data_q <= cresp_data;
            end
            if (state_q == ST_WRBACK && mem_req_ready) begin
                wb_pend_q <= 1'b0;
            end
            if (state_q == ST_MEMWT && mem_resp_valid) begin
                line_data_q <= mem_resp_data;
            end
        end
    end

    // Outputs
    always_comb begin
        creq_ready       = 1'b0;
        cresp_ready      = 1'b0;
        dgreq_valid      = 1'b0;
        grant_valid      = 1'b0;
        mem_req_valid    = 1'b0;
        mem_req_write    = 1'b0;
        mem_resp_ready   = 1'b0;
        unique case (state_q)
            ST_IDLE:   creq_ready = 1'b1;
            ST_DNGRD: begin
                cresp_ready = 1'b1;
                dgreq_valid = (send_mask != '0);
            end
            ST_WRBACK: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
            end
            ST_MEMRD:  mem_req_valid  = 1'b1;
            ST_MEMWT:  mem_resp_ready = 1'b1;
            ST_GRANT:  grant_valid    = 1'b1;
            default: ;
        endcase
        dgreq_child      = pick;
        dgreq_line       = req_line_q;
        dgreq_state      = (want_q == MSI_M) ? MSI_I : MSI_S;
        grant_child      = req_child_q;
        grant_line       = req_line_q;
        grant_state      = want_q;
        grant_data_valid = (cur_q == MSI_I);
        grant_data       = line_data_q;
        mem_req_line     = req_line_q;
        mem_req_data     = wb_data_q;
    end

    // R4
    grant_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (wait_mask == '0 && send_mask == '0));

    // R5
    read_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> !wb_pend_q);

    // R6
    read_only_from_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_write) |-> (cur_q == MSI_I));

    // R3
    dg_other_child_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dgreq_valid |-> (dgreq_child != req_child_q && dgreq_state != MSI_M));

    // R3
    dg_resp_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cresp_fire |-> (cresp_line == req_line_q));

    // R10
    one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (creq_valid && creq_ready) |=> !creq_ready);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        creq_ready |-> (!grant_valid && !dgreq_valid && !mem_req_valid));

endmodule

// File: tb/msi_dir_ctrl_tb_top.sv
module msi_dir_ctrl_tb_top;

    localparam int NC = 2;
    localparam int ROWS = 16;
    localparam int LW = 26;
    localparam int DW = 64;
    localparam int MEM_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          creq_valid = 0, creq_ready;
    logic          creq_child = 0;
    logic [LW-1:0] creq_line = 0;
    logic [1:0]    creq_state = 0;
    logic          cresp_valid = 0, cresp_ready;
    logic          cresp_child = 0;
    logic [LW-1:0] cresp_line = 0;
    logic [1:0]    cresp_state = 0;
    logic [DW-1:0] cresp_data = 0;
    logic          dgreq_valid, dgreq_child;
    logic          dgreq_ready = 1;
    logic [LW-1:0] dgreq_line;
    logic [1:0]    dgreq_state;
    logic          grant_valid, grant_child, grant_data_valid;
    logic          grant_ready = 1;
    logic [LW-1:0] grant_line;
    logic [1:0]    grant_state;
    logic [DW-1:0] grant_data;
    logic          mem_req_valid, mem_req_write, mem_resp_ready;
    logic          mem_req_ready = 1;
    logic [LW-1:0] mem_req_line;
    logic [DW-1:0] mem_req_data;
    logic          mem_resp_valid = 0;
    logic [DW-1:0] mem_resp_data = 0;

    msi_dir_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .creq_valid(creq_valid), .creq_ready(creq_ready), .creq_child(creq_child),
        .creq_line(creq_line), .creq_state(creq_state),
        .cresp_valid(cresp_valid), .cresp_ready(cresp_ready), .cresp_child(cresp_child),
        .cresp_line(cresp_line), .cresp_state(cresp_state), .cresp_data(cresp_data),
        .dgreq_valid(dgreq_valid), .dgreq_ready(dgreq_ready), .dgreq_child(dgreq_child),
        .dgreq_line(dgreq_line), .dgreq_state(dgreq_state),
        .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_child(grant_child),
        .grant_line(grant_line), .grant_state(grant_state),
        .grant_data_valid(grant_data_valid), .grant_data(grant_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_line(mem_req_line),
        .mem_req_data(mem_req_data),
        .mem_resp_valid(mem_resp_valid), .mem_resp_ready(mem_resp_ready),
        .mem_resp_data(mem_resp_data)
    );

    int checks = 0;
    int fails = 0;
    int txn_no = 0;

    // Behavioural model of the child caches and of memory
    logic [LW-1:0] m_line [NC][ROWS];
    logic [1:0]    m_st   [NC][ROWS];
    logic [DW-1:0] m_dat  [NC][ROWS];
    logic [DW-1:0] mem    [logic [LW-1:0]];

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_rd(logic [LW-1:0] ln);
        if (mem.exists(ln)) return mem[ln];
        return {ln, ~ln, 12'hA5C};
    endfunction

    function automatic logic [1:0] eff(int c, logic [LW-1:0] ln);
        if (m_line[c][ln[3:0]] == ln) return m_st[c][ln[3:0]];
        return 2'd0;
    endfunction

    task automatic run_txn(int ch, logic [LW-1:0] ln, logic [1:0] want, int exp_lat);
        int idx;
        logic [1:0] own, tgt, e;
        logic [NC-1:0] exp_dg, seen_dg;
        bit exp_wb, wb_seen, exp_rd, rd_seen, done, busy_ok;
        logic [DW-1:0] wb_exp, data_exp, mem_val;
        int rd_iter, mem_due;
        int dq_child[$];
        int dq_due[$];
        idx = int'(ln[3:0]);
        own = eff(ch, ln);
        tgt = (want == 2'd2) ? 2'd0 : 2'd1;
        exp_dg = '0; seen_dg = '0; exp_wb = 0; wb_seen = 0; rd_seen = 0;
        done = 0; busy_ok = 1; wb_exp = '0; rd_iter = -1; mem_due = -1; mem_val = '0;
        for (int c = 0; c < NC; c++) begin
            if (c != ch) begin
                e = eff(c, ln);
                if ((want == 2'd2 && e != 2'd0) || (want == 2'd1 && e == 2'd2)) exp_dg[c] = 1'b1;
                if (e == 2'd2) begin
                    exp_wb = 1;
                    wb_exp = m_dat[c][idx];
                end
            end
        end
        exp_rd = (own == 2'd0);
        data_exp = exp_wb ? wb_exp : mem_rd(ln);
        txn_no++;

        @(negedge clk);
        creq_valid = 1; creq_child = ch[0]; creq_line = ln; creq_state = want;
        // R10: idle controller accepts the request
        chk(creq_ready == 1'b1, "R10", "creq_ready when idle", 64'(creq_ready), 64'd1);
        @(negedge clk);
        creq_valid = 0;
        for (int it = 1; it <= 400 && !done; it++) begin
            cresp_valid = 0;
            mem_resp_valid = 0;
            if (creq_ready) busy_ok = 0;
            if (dgreq_valid) begin
                // R3
                chk(exp_dg[dgreq_child] && !seen_dg[dgreq_child], "R3", "downgrade child",
                    64'(dgreq_child), 64'(exp_dg));
                chk(dgreq_state == tgt, "R3", "downgrade target", 64'(dgreq_state), 64'(tgt));
                chk(dgreq_line == ln, "R3", "downgrade line", 64'(dgreq_line), 64'(ln));
                seen_dg[dgreq_child] = 1'b1;
                dq_child.push_back(int'(dgreq_child));
                dq_due.push_back(it + 2);
            end
            if (mem_req_valid) begin
                chk(mem_req_line == ln, "R6", "memory line", 64'(mem_req_line), 64'(ln));
                if (mem_req_write) begin
                    // R5
                    chk(exp_wb && !wb_seen, "R5", "unexpected writeback", 64'(wb_seen), 64'(exp_wb));
                    chk(mem_req_data == wb_exp, "R5", "writeback data", mem_req_data, wb_exp);
                    wb_seen = 1;
                    mem[ln] = mem_req_data;
                end else begin
                    // R6 / R7
                    chk(exp_rd && !rd_seen, "R7", "memory read issued", 64'(rd_seen), 64'(exp_rd));
                    // R5: dirty data reaches memory before the read
                    chk(wb_seen == exp_wb, "R5", "writeback before read", 64'(wb_seen), 64'(exp_wb));
                    if (exp_dg == '0) begin
                        // R9
                        chk(it == 2, "R9", "read issue cycle", 64'(it), 64'd2);
                    end
                    rd_seen = 1;
                    rd_iter = it;
                    mem_due = it + MEM_LAT;
                    mem_val = mem_rd(ln);
                end
            end
            if (grant_valid) begin
                chk(grant_child == ch[0], "R8", "grant child", 64'(grant_child), 64'(ch));
                chk(grant_line == ln, "R8", "grant line", 64'(grant_line), 64'(ln));
                chk(grant_state == want, "R8", "grant state", 64'(grant_state), 64'(want));
                chk(grant_data_valid == exp_rd, "R6", "grant data valid", 64'(grant_data_valid), 64'(exp_rd));
                if (exp_rd) chk(grant_data == data_exp, "R6", "grant data", grant_data, data_exp);
                // R4
                chk(seen_dg == exp_dg, "R4", "downgrades sent", 64'(seen_dg), 64'(exp_dg));
                chk(dq_child.size() == 0, "R4", "responses outstanding", 64'(dq_child.size()), 64'd0);
                chk(wb_seen == exp_wb, "R5", "writeback seen", 64'(wb_seen), 64'(exp_wb));
                chk(rd_seen == exp_rd, "R7", "read seen", 64'(rd_seen), 64'(exp_rd));
                if (exp_lat > 0) chk(it == exp_lat, "R9", "grant cycle", 64'(it), 64'(exp_lat));
                if (rd_seen) chk(it == rd_iter + MEM_LAT + 1, "R9", "grant after read data",
                                 64'(it), 64'(rd_iter + MEM_LAT + 1));
                // R10
                chk(busy_ok, "R10", "request refused while busy", 64'(busy_ok), 64'd1);
                done = 1;
            end
            if (!done) begin
                if (mem_due == it) begin
                    mem_resp_valid = 1;
                    mem_resp_data = mem_val;
                end
                if (dq_due.size() > 0 && dq_due[0] <= it) begin
                    int c;
                    c = dq_child.pop_front();
                    void'(dq_due.pop_front());
                    cresp_valid = 1;
                    cresp_child = c[0];
                    cresp_line = ln;
                    cresp_state = tgt;
                    cresp_data = (eff(c, ln) == 2'd2) ? m_dat[c][idx] : 64'h0BAD_0BAD_0BAD_0BAD;
                end
                @(negedge clk);
            end
        end
        if (!done) chk(0, "R4", "grant never arrived", 64'd0, 64'd1);

        for (int c = 0; c < NC; c++) begin
            if (exp_dg[c]) m_st[c][idx] = tgt;
        end
        m_line[ch][idx] = ln;
        m_st[ch][idx] = want;
        if (exp_rd) m_dat[ch][idx] = data_exp;
        if (want == 2'd2) m_dat[ch][idx] = {8'hD0 + 8'(ch), 8'(txn_no), 22'h0, ln};
    endtask

    localparam logic [LW-1:0] LINE_A = 26'h0000123;
    localparam logic [LW-1:0] LINE_B = 26'h0000453;
    localparam logic [LW-1:0] LINE_C = 26'h00007A5;

    initial begin
        for (int c = 0; c < NC; c++) begin
            for (int r = 0; r < ROWS; r++) begin
                m_line[c][r] = '1;
                m_st[c][r] = 2'd0;
                m_dat[c][r] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(creq_ready == 1'b1, "R1", "ready after reset", 64'(creq_ready), 64'd1);
        chk(!dgreq_valid && !grant_valid && !mem_req_valid, "R1", "outputs idle after reset",
            64'({dgreq_valid, grant_valid, mem_req_valid}), 64'd0);

        run_txn(0, LINE_A, 2'd1, -1);  // R1: cold miss, no downgrade
        run_txn(1, LINE_A, 2'd1, -1);  // sharers coexist
        run_txn(1, LINE_A, 2'd2, -1);  // R3/R7: S to M, invalidate other sharer
        run_txn(0, LINE_A, 2'd1, -1);  // R3/R5: M owner downgraded to S, dirty writeback
        run_txn(0, LINE_A, 2'd2, -1);  // R7: S to M with sharer invalidated
        run_txn(1, LINE_B, 2'd1, -1);  // R2: same row, other tag, no downgrade
        run_txn(1, LINE_C, 2'd2, -1);  // R6: miss for M
        run_txn(0, LINE_C, 2'd2, -1);  // R5: M to I with writeback, data forwarded via memory
        run_txn(1, LINE_B, 2'd2, 2);   // R9/R2: S to M, no conflict, fixed latency
        run_txn(0, LINE_C, 2'd1, 2);   // R8: already M in shadow, grant with no data at cycle 2

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule